// File: doc/BRIEF.md
# Digital PLL Lock Detector

This block decides whether a phase-locked loop has settled. It watches the divided reference signal and the divided feedback signal. On each phase-detector cycle it counts the periods of a fast measurement clock between the rising edge that arrives first and the rising edge that arrives second. Either signal may lead. The count is the phase error for that cycle.

Two thresholds give the detector hysteresis. A cycle whose error is below the tight lock threshold is a good cycle. Lock is declared only after a selectable number of consecutive good cycles, either three or five. Once declared, lock holds until a cycle shows an error above the looser unlock threshold. Cycles whose error falls between the two thresholds have no effect on a lock that is already declared. They break an acquisition that is still in progress.

The two divided signals must already be synchronous to the measurement clock. The count-select input is sampled each time a cycle is evaluated.

Top module: `pll_lock_detect`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the lock flag and the consecutive-good count, so that the full count of good cycles is needed after reset.
- R2: The phase error is the number of `clk` periods between the rising edge of `refDiv` or `fbDiv` that comes first and the rising edge of the other signal. Edges seen in the same cycle give an error of 0. The measurement is the same whichever signal leads.
- R3: With `countSel` = 0, `lockOut` rises after three consecutive cycles with error below `LOCK_THR` (default 6), and not after two.
- R4: With `countSel` = 1, five consecutive good cycles are needed: `lockOut` stays low after four and rises after the fifth.
- R5: While `lockOut` is high, a cycle with error at most `UNLOCK_THR` (default 10) leaves it high. This includes errors from `LOCK_THR` up to `UNLOCK_THR`.
- R6: While `lockOut` is high, a cycle with error above `UNLOCK_THR` drops it. An error beyond the timer range saturates at the timer maximum and counts as above `UNLOCK_THR`.
- R7: While `lockOut` is low, a cycle with error of at least `LOCK_THR` resets the consecutive-good count to zero.
- R8: Losing lock clears the consecutive-good count, so a full three or five good cycles are needed to lock again.
- R9: `lockOut` changes only as the result of an evaluated cycle or a reset. It never rises without a good cycle and never falls without a bad cycle or a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Measurement clock |
| rst | input | 1 | Synchronous reset, active high |
| refDiv | input | 1 | Divided reference signal, synchronous to clk |
| fbDiv | input | 1 | Divided feedback signal, synchronous to clk |
| countSel | input | 1 | 0: three good cycles to lock; 1: five |
| lockOut | output | 1 | Lock flag, active high |

## Verification
The assertions assume that each phase-detector cycle brings exactly one rising edge on each divided signal. They also assume the second edge of a pair arrives before the next pair starts, so that every evaluation is one clean pair. The stimulus follows this. Each cycle raises the leading signal, waits the chosen error in clock periods, then raises the other signal. Both signals are then held low for a long quiet gap before the next cycle starts. The random errors are drawn around both thresholds and include occasional values beyond the timer range.

// File: rtl/pll_ld_pkg.sv
package pll_ld_pkg;
  // Result of one evaluated phase-detector cycle, registered in the datapath
  typedef struct packed {
    logic done;  // one-cycle strobe: a phase error was measured
    logic good;  // error below the lock threshold
    logic bad;   // error above the unlock threshold
  } pdStrobe_t;

  typedef enum logic {ST_UNLOCKED = 1'b0, ST_LOCKED = 1'b1} lockState_t;
endpackage

// File: rtl/pll_ld_datapath.sv
module pll_ld_datapath #(
  parameter int TIMER_W    = 6,
  parameter int LOCK_THR   = 6,
  parameter int UNLOCK_THR = 10
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   refDiv,
  input  logic                   fbDiv,
  output pll_ld_pkg::pdStrobe_t  stb
);
  localparam logic [TIMER_W-1:0] TIMER_MAX = {TIMER_W{1'b1}};
  localparam logic [TIMER_W-1:0] LOCK_LIM  = TIMER_W'(LOCK_THR);
  localparam logic [TIMER_W-1:0] UNLK_LIM  = TIMER_W'(UNLOCK_THR);

  logic refPrev, fbPrev;
  logic refRise, fbRise;
  logic measuring, waitFb;
  logic [TIMER_W-1:0] timer;
  logic finishNow;
  logic [TIMER_W-1:0] errNow;

  assign refRise = refDiv & ~refPrev;
  assign fbRise  = fbDiv & ~fbPrev;

  always_comb begin
    finishNow = 1'b0;
    errNow    = '0;
    if (!measuring) begin
      finishNow = refRise & fbRise;
    end else begin
      finishNow = waitFb ? fbRise : refRise;
      errNow    = timer;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      refPrev   <= 1'b0;
      fbPrev    <= 1'b0;
      measuring <= 1'b0;
      waitFb    <= 1'b0;
      timer     <= '0;
      stb       <= '0;
    end else begin
      refPrev  <= refDiv;
      fbPrev   <= fbDiv;
      stb.done <= finishNow;
      if (finishNow) begin
        stb.good  <= (errNow < LOCK_LIM);
        stb.bad   <= (errNow > UNLK_LIM);
        measuring <= 1'b0;
      end else if (!measuring) begin
        if (refRise || fbRise) begin
          measuring <= 1'b1;
          waitFb    <= refRise;
          timer     <= TIMER_W'(1);
        end
      end else if (timer != TIMER_MAX) begin
        timer <= timer + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pll_ld_control.sv
module pll_ld_control #(
  parameter int LOCK_CNT_LO = 3,
  parameter int LOCK_CNT_HI = 5
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  countSel,
  input  pll_ld_pkg::pdStrobe_t stb,
  output logic                  lockOut
);
  import pll_ld_pkg::*;
  localparam int GC_W = $clog2(LOCK_CNT_HI + 1);

  lockState_t state;
  logic [GC_W-1:0] goodCnt;
  logic [GC_W-1:0] needCnt;
  logic [GC_W-1:0] goodNext;

  assign needCnt  = countSel ? GC_W'(LOCK_CNT_HI) : GC_W'(LOCK_CNT_LO);
  assign goodNext = goodCnt + 1'b1;
  assign lockOut  = (state == ST_LOCKED);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_UNLOCKED;
      goodCnt <= '0;
    end else if (stb.done) begin
      if (state == ST_LOCKED) begin
        if (stb.bad) begin
          state   <= ST_UNLOCKED;
          goodCnt <= '0;
        end
      end else if (stb.good) begin
        if (goodNext >= needCnt) begin
          state   <= ST_LOCKED;
          goodCnt <= '0;
        end else begin
          goodCnt <= goodNext;
        end
      end else begin
        goodCnt <= '0;
      end
    end
  end
endmodule

// File: rtl/pll_lock_detect.sv
module pll_lock_detect #(
  parameter int TIMER_W     = 6,
  parameter int LOCK_THR    = 6,
  parameter int UNLOCK_THR  = 10,
  parameter int LOCK_CNT_LO = 3,
  parameter int LOCK_CNT_HI = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic refDiv,
  input  logic fbDiv,
  input  logic countSel,
  output logic lockOut
);
  pll_ld_pkg::pdStrobe_t stb;

  pll_ld_datapath #(
    .TIMER_W(TIMER_W), .LOCK_THR(LOCK_THR), .UNLOCK_THR(UNLOCK_THR)
  ) dp_i (
    .clk(clk), .rst(rst), .refDiv(refDiv), .fbDiv(fbDiv), .stb(stb)
  );

  pll_ld_control #(
    .LOCK_CNT_LO(LOCK_CNT_LO), .LOCK_CNT_HI(LOCK_CNT_HI)
  ) ctl_i (
    .clk(clk), .rst(rst), .countSel(countSel), .stb(stb), .lockOut(lockOut)
  );
endmodule

// File: rtl/pll_lock_detect_chk.sv
module pll_lock_detect_chk (
  input logic                  clk,
  input logic                  rst,
  input logic                  lockOut,
  input pll_ld_pkg::pdStrobe_t stb
);
  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> !lockOut); // R1

  AST_RISE_NEEDS_GOOD: assert property (@(posedge clk) disable iff (rst)
    $rose(lockOut) |-> $past(stb.done && stb.good)); // R9

  AST_FALL_NEEDS_BAD: assert property (@(posedge clk) disable iff (rst)
    ($fell(lockOut) && !$past(rst)) |-> $past(stb.done && stb.bad)); // R6

  AST_HOLD_WITHOUT_BAD: assert property (@(posedge clk) disable iff (rst)
    (lockOut && !(stb.done && stb.bad)) |=> lockOut); // R5

  AST_STROBE_CLASSES: assert property (@(posedge clk) disable iff (rst)
    stb.done |-> !(stb.good && stb.bad)); // R2
endmodule

bind pll_lock_detect pll_lock_detect_chk chk_i (
  .clk(clk), .rst(rst), .lockOut(lockOut), .stb(stb)
);

// File: tb/pll_lock_detect_tb_top.sv
module pll_lock_detect_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LOCK_THR   = 6;
  localparam int UNLOCK_THR = 10;
  localparam int TIMER_MAX  = 63;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic refDiv = 1'b0, fbDiv = 1'b0, countSel = 1'b0;
  logic lockOut;

  int checks = 0, errors = 0;
  bit finished = 1'b0;
  bit mLock = 1'b0;
  int mGood = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pll_lock_detect dut_i (
    .clk(clk), .rst(rst), .refDiv(refDiv), .fbDiv(fbDiv),
    .countSel(countSel), .lockOut(lockOut)
  );

  function automatic bit isGood(int e);
    return ((e > TIMER_MAX ? TIMER_MAX : e) < LOCK_THR);
  endfunction
  function automatic bit isBad(int e);
    return ((e > TIMER_MAX ? TIMER_MAX : e) > UNLOCK_THR);
  endfunction

  task automatic modelStep(int e);
    int need = countSel ? 5 : 3;
    if (mLock) begin
      if (isBad(e)) begin mLock = 1'b0; mGood = 0; end
    end else if (isGood(e)) begin
      mGood++;
      if (mGood >= need) begin mLock = 1'b1; mGood = 0; end
    end else mGood = 0;
  endtask

  task automatic check(string tag, bit exp);
    checks++;
    if (lockOut !== exp) begin
      errors++;
      $display("FAIL %s: lockOut=%b expected=%b", tag, lockOut, exp);
    end
  endtask

  // one phase-detector cycle with error e clock periods; fbFirst picks leader
  task automatic pdCycle(int e, bit fbFirst, string tag);
    @(negedge clk);
    if (e == 0) begin refDiv = 1'b1; fbDiv = 1'b1; end
    else if (fbFirst) fbDiv = 1'b1;
    else refDiv = 1'b1;
    repeat (e) @(negedge clk);
    refDiv = 1'b1; fbDiv = 1'b1;
    repeat (2) @(negedge clk);
    refDiv = 1'b0; fbDiv = 1'b0;
    repeat (20) @(negedge clk);
    modelStep(e);
    check(tag, mLock);
  endtask

  task automatic doReset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 during reset", 1'b0);
    rst = 1'b0; mLock = 1'b0; mGood = 0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1 reset state", 1'b0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // R3: three good cycles, count-select 0
    countSel = 1'b0;
    pdCycle(2, 0, "R3 good 1");
    pdCycle(5, 1, "R3 good 2 not locked");
    pdCycle(0, 0, "R3 third good locks");
    // R5: in-between and threshold errors keep lock
    pdCycle(LOCK_THR, 0, "R5 at lock thr holds");
    pdCycle(UNLOCK_THR, 1, "R5 at unlock thr holds");
    // R6: just above unlock drops
    pdCycle(UNLOCK_THR + 1, 0, "R6 above unlock drops");
    // R8: after loss, full count again
    pdCycle(1, 0, "R8 good 1 after loss");
    pdCycle(1, 1, "R8 good 2 after loss");
    pdCycle(1, 0, "R8 third relocks");
    // R6: saturating timer counts as bad
    pdCycle(70, 1, "R6 saturated error drops");

    // R7: in-between while unlocked restarts the count
    pdCycle(3, 0, "R7 good 1");
    pdCycle(4, 1, "R7 good 2");
    pdCycle(8, 0, "R7 in-between resets");
    pdCycle(3, 1, "R7 good 1 again");
    pdCycle(3, 0, "R7 good 2 again");
    pdCycle(LOCK_THR - 1, 1, "R7 R2 good 3 locks");

    // R1: mid-run reset clears lock and count
    doReset();
    pdCycle(1, 0, "R1 good 1 after reset");
    pdCycle(1, 0, "R1 good 2 after reset");

    // R4: five good cycles with count-select 1
    doReset();
    countSel = 1'b1;
    for (int i = 0; i < 4; i++) pdCycle(i + 1, i[0], "R4 good not yet locked");
    pdCycle(5, 1, "R4 fifth good locks");
    pdCycle(UNLOCK_THR + 4, 1, "R6 R2 fb leads bad drops");

    // random mix
    for (int i = 0; i < 400; i++) begin
      int r = $urandom_range(0, 99);
      int e;
      if (r < 55) e = $urandom_range(0, LOCK_THR - 1);
      else if (r < 75) e = $urandom_range(LOCK_THR, UNLOCK_THR);
      else if (r < 95) e = $urandom_range(UNLOCK_THR + 1, UNLOCK_THR + 8);
      else e = $urandom_range(TIMER_MAX - 2, TIMER_MAX + 6);
      if ($urandom_range(0, 19) == 0) countSel = ~countSel;
      pdCycle(e, $urandom_range(0, 1) == 1, "R9 R2 random cycle");
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule